// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block gives software on a CPU a one-byte channel to an external debugger. The CPU stores a byte through its simple I/O bus. That write also raises a dirty flag. The debugger sees the whole stored byte and the flag on a parallel port. When the debugger has taken the byte, it pulses a read-acknowledge, and that clears the flag. When the CPU reads the mailbox back, it gets the low seven stored bits with the flag placed in the top bit.

The mailbox can share its bus address with an ordinary I/O register. The CPU reaches the mailbox only when two conditions hold: the debug-enable fuse is programmed, and the debugger has raised its access enable. In every other case the ordinary register answers at that address. The block keeps the fuse and lock state that controls this steering. While any lock bit is set, a request to program the debug-enable fuse is refused, and a one-cycle error pulse reports the refusal. A chip erase clears the lock bits, and after that the fuse can be programmed. A test-port enable output combines a second fuse with a disable control bit.

Top module: `dbg_mailbox`

## Requirements
- R1: While rst is high and on the first cycle after it, the mailbox byte, dirty flag and shared I/O register are 0. The debug-enable fuse is 0 (unprogrammed), the test-port fuse is 1 (programmed), both lock bits are 0 and fuse_prog_err is 0.
- R2: When the gate is open, a cpu_wr at address MBX_ADDR (default 6'h31) stores cpu_wdata. From the next cycle, dbg_rd_data shows all eight bits and dbg_flag is 1. The gate is open when dbg_fuse_q is 1 and dbg_acc_en is 1.
- R3: A cpu_rd of MBX_ADDR with the gate open returns, in the same cycle, cpu_rdata[7] = dirty flag and cpu_rdata[6:0] = stored bits 6:0.
- R4: A dbg_rd_ack pulse with no mailbox write in that cycle clears dbg_flag on the next cycle. Without an acknowledge, the flag stays set however long the port is observed.
- R5: If a mailbox write and dbg_rd_ack fall in the same cycle, the write wins. The flag stays 1 and dbg_rd_data shows the new byte.
- R6: When the gate is closed, reads and writes of MBX_ADDR reach the shared I/O register, which reads back all eight bits. The mailbox byte and flag are left unchanged.
- R7: Writes to any other address change nothing, and cpu_rdata is 0 for reads of other addresses or when cpu_rd is 0.
- R8: A dbg_fuse_prog_req while any lock bit is 1 leaves dbg_fuse_q unchanged. It raises fuse_prog_err for exactly the following cycle.
- R9: chip_erase_req clears both lock bits on the next cycle. A fuse program request in the same cycle as the erase is still judged against the old locks. A request after the erase is accepted, with no error.
- R10: lock_prog_req[i] sets lock bit i on the next cycle. When chip_erase_req is in the same cycle, the erase wins.
- R11: dbg_port_en is 1 exactly when port_fuse_q is 1 and port_dis is 0.
- R12: The fuse clear requests (dbg_fuse_clr_req, port_fuse_clr_req) always take effect on the next cycle and win over a program request in the same cycle. port_fuse_prog_req sets port_fuse_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| dbg_acc_en | input | 1 | Debugger access enable for the shared address |
| dbg_rd_ack | input | 1 | Debugger has consumed the mailbox byte |
| dbg_rd_data | output | 8 | Stored mailbox byte |
| dbg_flag | output | 1 | Dirty flag |
| dbg_fuse_prog_req | input | 1 | Request to program the debug-enable fuse |
| dbg_fuse_clr_req | input | 1 | Request to clear the debug-enable fuse |
| port_fuse_prog_req | input | 1 | Request to program the test-port fuse |
| port_fuse_clr_req | input | 1 | Request to clear the test-port fuse |
| lock_prog_req | input | 2 | Per-bit lock programming requests |
| chip_erase_req | input | 1 | Chip erase, clears lock bits |
| port_dis | input | 1 | Test-port disable control bit |
| dbg_fuse_q | output | 1 | Debug-enable fuse state |
| port_fuse_q | output | 1 | Test-port fuse state |
| lock_q | output | 2 | Lock bit state |
| fuse_prog_err | output | 1 | One-cycle pulse on a refused fuse program |
| dbg_port_en | output | 1 | Test-port enable |

## Verification
The hardest state to reach is a refused fuse program that coincides with a chip erase. In that cycle the old lock state must decide the outcome even though the locks vanish on the same edge. The stimulus first sets a lock bit, clears the debug fuse, and then issues the erase and the program request together. It checks for the error pulse, the unchanged fuse and the cleared locks, and then retries the request alone. The gated steering is reached by walking the fuse and access-enable combinations while a known value sits in the shared register. A full sweep of all 256 bytes drives write, read-back and acknowledge.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

    localparam int DATA_W = 8;
    localparam int LOCK_N = 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MBX  = 2'd1,
        TGT_IO   = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              dirty;
    } mbx_t;

    typedef struct packed {
        logic              dbg_fuse;
        logic              port_fuse;
        logic [LOCK_N-1:0] lock;
    } cfg_t;

    // CPU view of the mailbox: flag replaces the top data bit
    function automatic logic [DATA_W-1:0] cpu_view(input mbx_t m);
        return {m.dirty, m.data[DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/dbgmb_steer.sv
module dbgmb_steer
    import dbgmb_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [5:0]  MBX_ADDR = 6'h31,
    parameter bit          SHARED   = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dbg_fuse,
    input  logic              acc_en,
    output tgt_e              tgt
);
    logic hit;
    assign hit = (addr == ADDR_W'(MBX_ADDR));

    generate
        if (SHARED) begin : g_shared
            always_comb begin
                if (!hit)                    tgt = TGT_NONE;
                else if (dbg_fuse && acc_en) tgt = TGT_MBX;
                else                         tgt = TGT_IO;
            end
        end else begin : g_private
            always_comb tgt = hit ? TGT_MBX : TGT_NONE;
        end
    endgenerate
endmodule

// File: rtl/dbgmb_mbx_reg.sv
module dbgmb_mbx_reg
    import dbgmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output mbx_t              q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.data  <= '0;
            q.dirty <= 1'b0;
        end else if (wr_en) begin
            q.data  <= wdata;
            q.dirty <= 1'b1;
        end else if (ack) begin
            q.dirty <= 1'b0;
        end
    end
endmodule

// File: rtl/dbgmb_io_reg.sv
module dbgmb_io_reg
    import dbgmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/dbgmb_fuse_lock.sv
module dbgmb_fuse_lock
    import dbgmb_pkg::*;
#(
    parameter bit DBG_FUSE_RST  = 1'b0,
    parameter bit PORT_FUSE_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_prog_req,
    input  logic              dbg_clr_req,
    input  logic              port_prog_req,
    input  logic              port_clr_req,
    input  logic [LOCK_N-1:0] lock_prog_req,
    input  logic              erase_req,
    output cfg_t              q,
    output logic              err
);
    logic locked;
    assign locked = |q.lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.dbg_fuse  <= DBG_FUSE_RST;
            q.port_fuse <= PORT_FUSE_RST;
            q.lock      <= '0;
            err         <= 1'b0;
        end else begin
            err <= dbg_prog_req && locked;

            if (dbg_clr_req)                   q.dbg_fuse <= 1'b0;
            else if (dbg_prog_req && !locked)  q.dbg_fuse <= 1'b1;

            if (port_clr_req)       q.port_fuse <= 1'b0;
            else if (port_prog_req) q.port_fuse <= 1'b1;

            if (erase_req) q.lock <= '0;
            else           q.lock <= q.lock | lock_prog_req;
        end
    end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [5:0] MBX_ADDR = 6'h31,
    parameter bit         SHARED   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              dbg_acc_en,
    input  logic              dbg_rd_ack,
    output logic [7:0]        dbg_rd_data,
    output logic              dbg_flag,
    input  logic              dbg_fuse_prog_req,
    input  logic              dbg_fuse_clr_req,
    input  logic              port_fuse_prog_req,
    input  logic              port_fuse_clr_req,
    input  logic [1:0]        lock_prog_req,
    input  logic              chip_erase_req,
    input  logic              port_dis,
    output logic              dbg_fuse_q,
    output logic              port_fuse_q,
    output logic [1:0]        lock_q,
    output logic              fuse_prog_err,
    output logic              dbg_port_en
);
    tgt_e              tgt;
    mbx_t              mbx_q;
    cfg_t              cfg_q;
    logic [DATA_W-1:0] io_q;

    dbgmb_steer #(.ADDR_W(ADDR_W), .MBX_ADDR(MBX_ADDR), .SHARED(SHARED)) u_steer (
        .addr     (cpu_addr),
        .dbg_fuse (cfg_q.dbg_fuse),
        .acc_en   (dbg_acc_en),
        .tgt      (tgt)
    );

    dbgmb_mbx_reg u_mbx (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cpu_wr && (tgt == TGT_MBX)),
        .wdata (cpu_wdata),
        .ack   (dbg_rd_ack),
        .q     (mbx_q)
    );

    dbgmb_io_reg u_io (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cpu_wr && (tgt == TGT_IO)),
        .wdata (cpu_wdata),
        .q     (io_q)
    );

    dbgmb_fuse_lock u_cfg (
        .clk           (clk),
        .rst           (rst),
        .dbg_prog_req  (dbg_fuse_prog_req),
        .dbg_clr_req   (dbg_fuse_clr_req),
        .port_prog_req (port_fuse_prog_req),
        .port_clr_req  (port_fuse_clr_req),
        .lock_prog_req (lock_prog_req),
        .erase_req     (chip_erase_req),
        .q             (cfg_q),
        .err           (fuse_prog_err)
    );

    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            case (tgt)
                TGT_MBX: cpu_rdata = cpu_view(mbx_q);
                TGT_IO:  cpu_rdata = io_q;
                default: cpu_rdata = '0;
            endcase
        end
    end

    assign dbg_rd_data = mbx_q.data;
    assign dbg_flag    = mbx_q.dirty;
    assign dbg_fuse_q  = cfg_q.dbg_fuse;
    assign port_fuse_q = cfg_q.port_fuse;
    assign lock_q      = cfg_q.lock;
    assign dbg_port_en = cfg_q.port_fuse && !port_dis;
endmodule

// File: rtl/dbgmb_checker.sv
module dbgmb_checker #(
    parameter int         ADDR_W   = 6,
    parameter logic [5:0] MBX_ADDR = 6'h31
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [7:0]        cpu_wdata,
    input logic              dbg_acc_en,
    input logic              dbg_rd_ack,
    input logic [7:0]        dbg_rd_data,
    input logic              dbg_flag,
    input logic              dbg_fuse_q,
    input logic              dbg_fuse_prog_req,
    input logic              dbg_fuse_clr_req,
    input logic [1:0]        lock_q,
    input logic              chip_erase_req,
    input logic              fuse_prog_err,
    input logic              port_fuse_q,
    input logic              port_dis,
    input logic              dbg_port_en
);
    logic gate_open, mbx_wr;
    assign gate_open = dbg_fuse_q && dbg_acc_en;
    assign mbx_wr    = cpu_wr && (cpu_addr == ADDR_W'(MBX_ADDR)) && gate_open;

    a_r2_write_sets_flag: assert property (@(posedge clk) disable iff (rst)
        mbx_wr |=> (dbg_flag && dbg_rd_data == $past(cpu_wdata)));

    a_r4_ack_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd_ack && !mbx_wr) |=> !dbg_flag);

    a_r5_write_beats_ack: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd_ack && mbx_wr) |=> dbg_flag);

    a_r6_closed_gate_holds: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> $stable(dbg_rd_data));

    a_r8_locked_refused: assert property (@(posedge clk) disable iff (rst)
        (dbg_fuse_prog_req && (|lock_q) && !dbg_fuse_q) |=> (!dbg_fuse_q && fuse_prog_err));

    a_r8_err_has_cause: assert property (@(posedge clk) disable iff (rst)
        fuse_prog_err |-> $past(dbg_fuse_prog_req && (|lock_q)));

    a_r10_erase_clears_locks: assert property (@(posedge clk) disable iff (rst)
        chip_erase_req |=> (lock_q == 2'b00));

    a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
        dbg_fuse_clr_req |=> !dbg_fuse_q);

    a_r11_port_enable: assert property (@(posedge clk) disable iff (rst)
        dbg_port_en |-> (port_fuse_q && !port_dis));
endmodule

bind dbg_mailbox dbgmb_checker #(.ADDR_W(ADDR_W), .MBX_ADDR(MBX_ADDR)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .cpu_addr          (cpu_addr),
    .cpu_wr            (cpu_wr),
    .cpu_wdata         (cpu_wdata),
    .dbg_acc_en        (dbg_acc_en),
    .dbg_rd_ack        (dbg_rd_ack),
    .dbg_rd_data       (dbg_rd_data),
    .dbg_flag          (dbg_flag),
    .dbg_fuse_q        (dbg_fuse_q),
    .dbg_fuse_prog_req (dbg_fuse_prog_req),
    .dbg_fuse_clr_req  (dbg_fuse_clr_req),
    .lock_q            (lock_q),
    .chip_erase_req    (chip_erase_req),
    .fuse_prog_err     (fuse_prog_err),
    .port_fuse_q       (port_fuse_q),
    .port_dis          (port_dis),
    .dbg_port_en       (dbg_port_en)
);

// File: tb/tb_dbg_mailbox.sv
module tb_dbg_mailbox;
    localparam logic [5:0] MA = 6'h31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       dbg_acc_en = 1'b0, dbg_rd_ack = 1'b0;
    logic [7:0] dbg_rd_data;
    logic       dbg_flag;
    logic       dbg_fuse_prog_req = 1'b0, dbg_fuse_clr_req = 1'b0;
    logic       port_fuse_prog_req = 1'b0, port_fuse_clr_req = 1'b0;
    logic [1:0] lock_prog_req = '0;
    logic       chip_erase_req = 1'b0, port_dis = 1'b0;
    logic       dbg_fuse_q, port_fuse_q, fuse_prog_err, dbg_port_en;
    logic [1:0] lock_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbg_mailbox dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; dbg_rd_ack = 0;
        dbg_fuse_prog_req = 0; dbg_fuse_clr_req = 0;
        port_fuse_prog_req = 0; port_fuse_clr_req = 0;
        lock_prog_req = '0; chip_erase_req = 0;
    endtask

    task automatic cpu_read(input logic [5:0] a, output logic [7:0] d);
        cpu_addr = a; cpu_rd = 1; #1; d = cpu_rdata; cpu_rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        step(); step();
        check("R1 reset data", dbg_rd_data, 0);
        check("R1 reset flag", dbg_flag, 0);
        rst = 0;
        step();
        check("R1 dbg fuse", dbg_fuse_q, 0);
        check("R1 port fuse", port_fuse_q, 1);
        check("R1 locks", lock_q, 0);
        check("R1 err", fuse_prog_err, 0);
        cpu_read(MA, rd); check("R1 io reg zero", rd, 0);

        // R11 / R12: sweep port fuse and disable bit
        for (int f = 0; f < 2; f++) begin
            if (f == 0) port_fuse_clr_req = 1; else port_fuse_prog_req = 1;
            step(); idle();
            check("R12 port fuse", port_fuse_q, f);
            for (int d = 0; d < 2; d++) begin
                port_dis = d[0]; #1;
                check("R11 port enable", dbg_port_en, (f == 1 && d == 0));
            end
        end
        port_dis = 0;
        port_fuse_prog_req = 1; port_fuse_clr_req = 1; step(); idle();
        check("R12 clear beats program", port_fuse_q, 0);

        // R6: gate closed because fuse unprogrammed
        dbg_acc_en = 1;
        cpu_addr = MA; cpu_wdata = 8'hDA; cpu_wr = 1; step(); idle();
        check("R6 mailbox untouched", dbg_rd_data, 0);
        check("R6 flag untouched", dbg_flag, 0);
        cpu_read(MA, rd); check("R6 io reg full byte", rd, 8'hDA);

        // program debug fuse, locks clear
        dbg_fuse_prog_req = 1; step(); idle();
        check("R9 fuse accepted unlocked", dbg_fuse_q, 1);
        check("R9 no err", fuse_prog_err, 0);

        // gate closed because access enable low
        dbg_acc_en = 0;
        cpu_addr = MA; cpu_wdata = 8'h3C; cpu_wr = 1; step(); idle();
        check("R6 acc_en low keeps mailbox", dbg_rd_data, 0);
        cpu_read(MA, rd); check("R6 io reg rewritten", rd, 8'h3C);
        dbg_acc_en = 1;

        // R2/R3/R4 sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            cpu_addr = MA; cpu_wdata = v[7:0]; cpu_wr = 1; step(); idle();
            check("R2 data", dbg_rd_data, v);
            check("R2 flag", dbg_flag, 1);
            cpu_read(MA, rd); check("R3 flag in bit7", rd, {1'b1, v[6:0]});
            dbg_rd_ack = 1; step(); idle();
            check("R4 ack clears", dbg_flag, 0);
            cpu_read(MA, rd); check("R3 cleared view", rd, {1'b0, v[6:0]});
        end

        // R4 polling without ack
        cpu_addr = MA; cpu_wdata = 8'h81; cpu_wr = 1; step(); idle();
        repeat (5) step();
        check("R4 polling keeps flag", dbg_flag, 1);

        // R5 write and ack together
        cpu_addr = MA; cpu_wdata = 8'h47; cpu_wr = 1; dbg_rd_ack = 1; step(); idle();
        check("R5 flag stays", dbg_flag, 1);
        check("R5 new byte", dbg_rd_data, 8'h47);

        // R6 io reg survived mailbox traffic
        dbg_acc_en = 0; cpu_read(MA, rd); check("R6 io reg retained", rd, 8'h3C);
        dbg_acc_en = 1;

        // R7 other addresses
        cpu_addr = 6'h10; cpu_wdata = 8'hEE; cpu_wr = 1; step(); idle();
        check("R7 mailbox unchanged", dbg_rd_data, 8'h47);
        cpu_read(6'h10, rd); check("R7 other addr reads 0", rd, 0);
        cpu_addr = MA; #1; check("R7 no rd strobe", cpu_rdata, 0);

        // R10 locks
        lock_prog_req = 2'b01; step(); idle();
        check("R10 lock set", lock_q, 2'b01);
        lock_prog_req = 2'b10; chip_erase_req = 1; step(); idle();
        check("R10 erase wins", lock_q, 2'b00);
        lock_prog_req = 2'b10; step(); idle();
        check("R10 lock 1 set", lock_q, 2'b10);

        // R8 refused program while locked
        dbg_fuse_clr_req = 1; step(); idle();
        check("R12 dbg fuse cleared", dbg_fuse_q, 0);
        dbg_fuse_prog_req = 1; step(); idle();
        check("R8 fuse unchanged", dbg_fuse_q, 0);
        check("R8 err pulse", fuse_prog_err, 1);
        step();
        check("R8 err one cycle", fuse_prog_err, 0);

        // R9 erase and program together: old locks decide
        dbg_fuse_prog_req = 1; chip_erase_req = 1; step(); idle();
        check("R9 same-cycle refused", dbg_fuse_q, 0);
        check("R9 same-cycle err", fuse_prog_err, 1);
        check("R9 locks cleared", lock_q, 0);
        dbg_fuse_prog_req = 1; step(); idle();
        check("R9 accepted after erase", dbg_fuse_q, 1);
        check("R9 no err after erase", fuse_prog_err, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule